// File: doc/BRIEF.md
# Quadrature and Trigger-Slaved Up/Down Counter

This block holds a 16-bit counter whose clocking is chosen by a 3-bit slave-mode field. In the free-running mode it advances once per clock while the enable input is high. In three quadrature modes it decodes two phase-shifted inputs A and B into up and down steps. In four trigger modes a selected trigger source drives it. That source is one of four internal trigger lines or a pulse formed from every transition of input A. The trigger can reload the counter, gate its clock, start it, or clock it directly.

All asynchronous inputs (A, B and the four trigger lines) pass through a synchronizer of two flops. Edges are found by comparing the synchronized level with its value one cycle earlier. A change on an input therefore reaches the counter on the third rising clock edge after it is applied. The counter wraps between 0 and the period value `period_i`, and each wrap gives a one-cycle update pulse. An active trigger edge gives a one-cycle trigger pulse. The interrupt request combines the two pulses under two enable bits.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: While `rst_ni` is low, `count_o`, `dir_down_o`, `upd_pulse_o`, `trg_pulse_o` and `irq_o` are all 0.
- R2: With `mode_sel_i` = 000 the counter increments on every clock while `count_en_i` is 1 and holds its value while it is 0.
- R3: A step up from a value at or above `period_i` loads 0. A step down from 0 loads `period_i`. Either wrap raises `upd_pulse_o` for exactly one cycle, in the same cycle as the new count.
- R4: With `mode_sel_i` = 001 the counter steps only on B transitions. A rising B with A high counts up, a rising B with A low counts down, and a falling B reverses both cases. Changes on A alone leave the count unchanged.
- R5: With `mode_sel_i` = 010 the counter steps only on A transitions. A rising A with B low counts up, a falling A with B high counts up, and the other two cases count down. Changes on B alone leave the count unchanged.
- R6: With `mode_sel_i` = 011 both channels step the counter, each under its rule from R4 and R5, which gives four counts per quadrature cycle. If A and B change in the same synchronized cycle, no step is taken.
- R7: `dir_down_o` is 1 after a down step and 0 after an up step in the quadrature modes. It holds through cycles without a step and reads 0 in modes 000 and 1xx.
- R8: With `mode_sel_i` = 100 the counter runs as in R2. A rising edge of the selected trigger loads 0 and raises `upd_pulse_o`, and this takes priority over the step in that cycle.
- R9: With `mode_sel_i` = 101 the counter increments each clock only while `count_en_i` is 1 and the synchronized trigger level is high. It holds, without clearing, while the trigger is low.
- R10: With `mode_sel_i` = 110 a rising trigger edge starts the counter, without clearing it, from that edge's cycle on, even with `count_en_i` at 0. A later fall of the trigger does not stop it. Leaving mode 110 drops the started state.
- R11: With `mode_sel_i` = 111 and `count_en_i` at 1, each rising trigger edge adds exactly one. A held trigger level adds nothing.
- R12: `trig_sel_i` values 000 to 011 select internal trigger lines 0 to 3. Value 100 selects the per-transition pulse of A, so every A change counts as a rising trigger edge. Values 101 to 111 select no trigger. Mode 101 is not meant to be combined with value 100.
- R13: `trg_pulse_o` rises for one cycle on each rising trigger edge, in modes 1xx only. `irq_o` is `upd_pulse_o` gated by `irq_en_i` bit 0, OR `trg_pulse_o` gated by `irq_en_i` bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Quadrature input A (asynchronous) |
| enc_b_i | input | 1 | Quadrature input B (asynchronous) |
| itrig_i | input | 4 | Internal trigger lines (asynchronous) |
| mode_sel_i | input | 3 | Slave-mode selection |
| trig_sel_i | input | 3 | Trigger source selection |
| count_en_i | input | 1 | Counter enable |
| period_i | input | 16 | Wrap limit (auto-reload value) |
| irq_en_i | input | 8 | Interrupt enables: bit 0 update, bit 6 trigger |
| count_o | output | 16 | Counter value |
| dir_down_o | output | 1 | 1 when the last quadrature step was down |
| upd_pulse_o | output | 1 | One-cycle update event |
| trg_pulse_o | output | 1 | One-cycle trigger event |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, two synchronizer stages and four trigger lines. It drives `period_i` to 9, so wraps up and down happen within a few steps of any count. A single quadrature table walks modes 001, 010 and 011 through forward, reverse, jitter and simultaneous-edge patterns. It ends on a down wrap and an up wrap. The fixed three-edge latency of the synchronizer lets each directed trigger test predict the exact cycle in which the count moves or stops.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [2:0] {
    SM_FREE   = 3'b000,
    SM_ENC_B  = 3'b001,
    SM_ENC_A  = 3'b010,
    SM_ENC_AB = 3'b011,
    SM_RESET  = 3'b100,
    SM_GATE   = 3'b101,
    SM_START  = 3'b110,
    SM_EXTCLK = 3'b111
  } slave_mode_e;

  localparam int unsigned TRIG_SEL_W  = 3;
  localparam int unsigned IRQ_EN_W    = 8;
  localparam int unsigned IRQ_UPD_BIT = 0;
  localparam int unsigned IRQ_TRG_BIT = 6;

endpackage

// File: rtl/tsc_sync_edge.sv
module tsc_sync_edge #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q[0] <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= chain_q[LAST];
  end

  assign lvl_o  = chain_q[LAST];
  assign rise_o = chain_q[LAST] & ~prev_q;
  assign fall_o = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/tsc_trig_sel.sv
module tsc_trig_sel #(
  parameter int unsigned NUM_ITR = 4,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [NUM_ITR-1:0] itr_lvl_i,
  input  logic [NUM_ITR-1:0] itr_rise_i,
  input  logic               a_edge_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               trig_lvl_o,
  output logic               trig_rise_o
);

  localparam logic [SEL_W-1:0] EDGE_CODE = SEL_W'(NUM_ITR);

  always_comb begin
    trig_lvl_o  = 1'b0;
    trig_rise_o = 1'b0;
    for (int i = 0; i < NUM_ITR; i++) begin
      if (sel_i == SEL_W'(i)) begin
        trig_lvl_o  = itr_lvl_i[i];
        trig_rise_o = itr_rise_i[i];
      end
    end
    // A transition pulse acts as both level and edge
    if (sel_i == EDGE_CODE) begin
      trig_lvl_o  = a_edge_i;
      trig_rise_o = a_edge_i;
    end
  end

endmodule

// File: rtl/tsc_mode_ctrl.sv
module tsc_mode_ctrl
  import tsc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  slave_mode_e mode_i,
  input  logic        en_i,
  input  logic        a_lvl_i,
  input  logic        b_lvl_i,
  input  logic        a_edge_i,
  input  logic        b_edge_i,
  input  logic        trig_lvl_i,
  input  logic        trig_rise_i,
  output logic        step_o,
  output logic        down_o,
  output logic        reload_o,
  output logic        trg_pulse_o,
  output logic        dir_down_o
);

  logic is_enc;
  logic a_step;
  logic b_step;
  logic enc_down;
  logic started_q;
  logic trg_q;
  logic dir_q;

  assign is_enc = (mode_i == SM_ENC_B) || (mode_i == SM_ENC_A) || (mode_i == SM_ENC_AB);

  // Simultaneous A and B changes in x4 decoding are discarded
  assign a_step = a_edge_i && ((mode_i == SM_ENC_A) || (mode_i == SM_ENC_AB && !b_edge_i));
  assign b_step = b_edge_i && ((mode_i == SM_ENC_B) || (mode_i == SM_ENC_AB && !a_edge_i));

  // A-edge: up when B low on rise or high on fall; B-edge mirrored
  assign enc_down = a_step ? ~(a_lvl_i ^ b_lvl_i) : (a_lvl_i ^ b_lvl_i);

  always_comb begin
    step_o   = 1'b0;
    down_o   = 1'b0;
    reload_o = 1'b0;
    unique case (mode_i)
      SM_FREE:   step_o = en_i;
      SM_ENC_B,
      SM_ENC_A,
      SM_ENC_AB: begin
        step_o = en_i && (a_step || b_step);
        down_o = enc_down;
      end
      SM_RESET: begin
        step_o   = en_i;
        reload_o = trig_rise_i;
      end
      SM_GATE:   step_o = en_i && trig_lvl_i;
      SM_START:  step_o = en_i || started_q || trig_rise_i;
      SM_EXTCLK: step_o = en_i && trig_rise_i;
      default:   step_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      trg_q     <= 1'b0;
      dir_q     <= 1'b0;
    end else begin
      if (mode_i != SM_START) started_q <= 1'b0;
      else if (trig_rise_i)   started_q <= 1'b1;

      trg_q <= trig_rise_i && mode_i[2];

      if (!is_enc)     dir_q <= 1'b0;
      else if (step_o) dir_q <= down_o;
    end
  end

  assign trg_pulse_o = trg_q;
  assign dir_down_o  = dir_q;

  // R6
  both_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_ENC_AB && a_edge_i && b_edge_i) |-> !step_o);

  // R13
  trg_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[2] |=> !trg_pulse_o);

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             down_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             upd_q;
  logic             upd_d;

  always_comb begin
    cnt_d = cnt_q;
    upd_d = 1'b0;
    if (reload_i) begin
      cnt_d = '0;
      upd_d = 1'b1;
    end else if (step_i) begin
      if (down_i) begin
        if (cnt_q == '0) begin
          cnt_d = limit_i;
          upd_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        if (cnt_q >= limit_i) begin
          cnt_d = '0;
          upd_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      upd_q <= upd_d;
    end
  end

  assign cnt_o = cnt_q;
  assign upd_o = upd_q;

  // R3
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !down_i && !reload_i && cnt_o == limit_i) |=> (cnt_o == '0 && upd_o));

  // R3
  down_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && down_i && !reload_i && cnt_o == '0) |=> (cnt_o == $past(limit_i) && upd_o));

  // R8
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cnt_o == '0 && upd_o));

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned NUM_ITR     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  enc_a_i,
  input  logic                  enc_b_i,
  input  logic [NUM_ITR-1:0]    itrig_i,
  input  logic [2:0]            mode_sel_i,
  input  logic [TRIG_SEL_W-1:0] trig_sel_i,
  input  logic                  count_en_i,
  input  logic [CNT_W-1:0]      period_i,
  input  logic [IRQ_EN_W-1:0]   irq_en_i,
  output logic [CNT_W-1:0]      count_o,
  output logic                  dir_down_o,
  output logic                  upd_pulse_o,
  output logic                  trg_pulse_o,
  output logic                  irq_o
);

  localparam int unsigned IN_W = NUM_ITR + 2;
  localparam int unsigned A_IX = NUM_ITR;
  localparam int unsigned B_IX = NUM_ITR + 1;

  slave_mode_e       mode;
  logic [IN_W-1:0]   raw_in;
  logic [IN_W-1:0]   in_lvl;
  logic [IN_W-1:0]   in_rise;
  logic [IN_W-1:0]   in_fall;
  logic              a_edge;
  logic              b_edge;
  logic              trig_lvl;
  logic              trig_rise;
  logic              step;
  logic              step_down;
  logic              reload;

  assign mode   = slave_mode_e'(mode_sel_i);
  assign raw_in = {enc_b_i, enc_a_i, itrig_i};

  tsc_sync_edge #(
    .WIDTH (IN_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(raw_in),
    .lvl_o  (in_lvl),
    .rise_o (in_rise),
    .fall_o (in_fall)
  );

  assign a_edge = in_rise[A_IX] | in_fall[A_IX];
  assign b_edge = in_rise[B_IX] | in_fall[B_IX];

  tsc_trig_sel #(
    .NUM_ITR(NUM_ITR),
    .SEL_W  (TRIG_SEL_W)
  ) u_trig_sel (
    .itr_lvl_i  (in_lvl[NUM_ITR-1:0]),
    .itr_rise_i (in_rise[NUM_ITR-1:0]),
    .a_edge_i   (a_edge),
    .sel_i      (trig_sel_i),
    .trig_lvl_o (trig_lvl),
    .trig_rise_o(trig_rise)
  );

  tsc_mode_ctrl u_mode_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .en_i       (count_en_i),
    .a_lvl_i    (in_lvl[A_IX]),
    .b_lvl_i    (in_lvl[B_IX]),
    .a_edge_i   (a_edge),
    .b_edge_i   (b_edge),
    .trig_lvl_i (trig_lvl),
    .trig_rise_i(trig_rise),
    .step_o     (step),
    .down_o     (step_down),
    .reload_o   (reload),
    .trg_pulse_o(trg_pulse_o),
    .dir_down_o (dir_down_o)
  );

  tsc_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .down_i  (step_down),
    .reload_i(reload),
    .limit_i (period_i),
    .cnt_o   (count_o),
    .upd_o   (upd_pulse_o)
  );

  assign irq_o = (upd_pulse_o & irq_en_i[IRQ_UPD_BIT])
               | (trg_pulse_o & irq_en_i[IRQ_TRG_BIT]);

  // R9
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SM_GATE && !trig_lvl) |=> $stable(count_o));

endmodule

// File: tb/test_tmr_slave_ctrl.sv
`timescale 1ns/1ps
module test_tmr_slave_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_a, enc_b;
  logic [3:0]  itrig;
  logic [2:0]  mode_sel, trig_sel;
  logic        count_en;
  logic [15:0] period;
  logic [7:0]  irq_en;
  logic [15:0] count;
  logic        dir_down, upd, trg, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  tmr_slave_ctrl i_tmr_slave_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .enc_a_i    (enc_a),
    .enc_b_i    (enc_b),
    .itrig_i    (itrig),
    .mode_sel_i (mode_sel),
    .trig_sel_i (trig_sel),
    .count_en_i (count_en),
    .period_i   (period),
    .irq_en_i   (irq_en),
    .count_o    (count),
    .dir_down_o (dir_down),
    .upd_pulse_o(upd),
    .trg_pulse_o(trg),
    .irq_o      (irq)
  );

  // {mode, A, B, expected count, expected dir_down}; period 9
  localparam int NVEC = 19;
  localparam logic [21:0] ENC_VEC [NVEC] = '{
    {3'b011, 1'b1, 1'b0, 16'd1, 1'b0},
    {3'b011, 1'b1, 1'b1, 16'd2, 1'b0},
    {3'b011, 1'b0, 1'b1, 16'd3, 1'b0},
    {3'b011, 1'b0, 1'b0, 16'd4, 1'b0},
    {3'b011, 1'b0, 1'b1, 16'd3, 1'b1},
    {3'b011, 1'b0, 1'b0, 16'd4, 1'b0},
    {3'b001, 1'b1, 1'b0, 16'd4, 1'b0},
    {3'b001, 1'b1, 1'b1, 16'd5, 1'b0},
    {3'b001, 1'b1, 1'b0, 16'd4, 1'b1},
    {3'b010, 1'b1, 1'b1, 16'd4, 1'b1},
    {3'b010, 1'b0, 1'b1, 16'd5, 1'b0},
    {3'b010, 1'b1, 1'b1, 16'd4, 1'b1},
    {3'b011, 1'b0, 1'b0, 16'd4, 1'b1},
    {3'b011, 1'b0, 1'b1, 16'd3, 1'b1},
    {3'b011, 1'b1, 1'b1, 16'd2, 1'b1},
    {3'b011, 1'b1, 1'b0, 16'd1, 1'b1},
    {3'b011, 1'b0, 1'b0, 16'd0, 1'b1},
    {3'b011, 1'b0, 1'b1, 16'd9, 1'b1},
    {3'b011, 1'b0, 1'b0, 16'd0, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0; itrig = '0;
    mode_sel = 3'b000; trig_sel = 3'b000; count_en = 1'b0;
    period = 16'd9; irq_en = 8'h00;
    @(negedge clk);
    tick(2);
    check("R1 count in reset", 32'(count), 0);
    check("R1 dir in reset", 32'(dir_down), 0);
    check("R1 upd in reset", 32'(upd), 0);
    check("R1 trg in reset", 32'(trg), 0);
    check("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
    tick(1);

    // Quadrature table
    count_en = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      mode_sel = ENC_VEC[i][21:19];
      enc_a    = ENC_VEC[i][18];
      enc_b    = ENC_VEC[i][17];
      tick(4);
      case (mode_sel)
        3'b001:  tag = $sformatf("R4 row %0d count", i);
        3'b010:  tag = $sformatf("R5 row %0d count", i);
        default: tag = $sformatf("R6 row %0d count", i);
      endcase
      check(tag, 32'(count), 32'(ENC_VEC[i][16:1]));
      check($sformatf("R7 row %0d dir", i), 32'(dir_down), 32'(ENC_VEC[i][0]));
    end

    // Free-running and up wrap
    mode_sel = 3'b000; count_en = 1'b0;
    tick(3);
    check("R2 hold when disabled", 32'(count), 0);
    check("R7 dir zero in mode 000", 32'(dir_down), 0);
    count_en = 1'b1;
    tick(5);
    check("R2 free count", 32'(count), 5);
    tick(4);
    check("R2 count at limit", 32'(count), 9);
    tick(1);
    check("R3 up wrap value", 32'(count), 0);
    check("R3 up wrap pulse", 32'(upd), 1);
    check("R13 irq masked", 32'(irq), 0);
    irq_en = 8'h01;
    tick(9);
    check("R2 count at limit again", 32'(count), 9);
    tick(1);
    check("R3 second wrap value", 32'(count), 0);
    check("R13 update irq", 32'(irq), 1);
    tick(1);
    check("R3 pulse one cycle", 32'(upd), 0);
    check("R3 count after wrap", 32'(count), 1);

    // Reset mode on trigger line 1
    mode_sel = 3'b100; trig_sel = 3'b001; irq_en = 8'h40; itrig[1] = 1'b1;
    tick(3);
    check("R8 reload value", 32'(count), 0);
    check("R8 reload update", 32'(upd), 1);
    check("R13 trigger pulse", 32'(trg), 1);
    check("R13 trigger irq", 32'(irq), 1);
    tick(1);
    check("R8 runs after reload", 32'(count), 1);
    check("R13 trigger pulse one cycle", 32'(trg), 0);
    itrig[1] = 1'b0;
    tick(3);
    check("R8 no reload on fall", 32'(count), 4);

    // Gated mode on trigger line 2
    mode_sel = 3'b101; trig_sel = 3'b010;
    tick(5);
    check("R9 held while gate low", 32'(count), 4);
    itrig[2] = 1'b1;
    tick(2);
    check("R9 sync latency", 32'(count), 4);
    tick(3);
    check("R9 counts while gate high", 32'(count), 7);
    itrig[2] = 1'b0;
    tick(5);
    check("R9 stops, not cleared", 32'(count), 9);

    // Start-only mode on trigger line 3
    mode_sel = 3'b110; trig_sel = 3'b011; count_en = 1'b0;
    tick(4);
    check("R10 idle before start", 32'(count), 9);
    itrig[3] = 1'b1;
    tick(3);
    check("R10 starts on edge", 32'(count), 0);
    check("R10 trigger pulse", 32'(trg), 1);
    itrig[3] = 1'b0;
    tick(6);
    check("R10 trigger fall does not stop", 32'(count), 6);
    mode_sel = 3'b000;
    tick(3);
    check("R10 stopped outside mode", 32'(count), 6);
    mode_sel = 3'b110;
    tick(3);
    check("R10 started state dropped", 32'(count), 6);

    // External clock mode
    mode_sel = 3'b111; trig_sel = 3'b000; count_en = 1'b1; itrig[0] = 1'b1;
    tick(3);
    check("R11 one step per edge", 32'(count), 7);
    tick(5);
    check("R11 level adds nothing", 32'(count), 7);
    itrig[0] = 1'b0;
    tick(4);
    check("R11 fall adds nothing", 32'(count), 7);
    trig_sel = 3'b100; enc_a = 1'b1;
    tick(4);
    check("R12 A rise as trigger", 32'(count), 8);
    enc_a = 1'b0;
    tick(4);
    check("R12 A fall as trigger", 32'(count), 9);
    trig_sel = 3'b101; enc_a = 1'b1; itrig[0] = 1'b1;
    tick(4);
    check("R12 reserved select count", 32'(count), 9);
    check("R12 reserved select trg", 32'(trg), 0);
    enc_a = 1'b0; itrig[0] = 1'b0;

    // No trigger event outside trigger modes
    mode_sel = 3'b000; count_en = 1'b0; trig_sel = 3'b000;
    tick(4);
    itrig[0] = 1'b1;
    tick(3);
    check("R13 no trigger pulse in mode 000", 32'(trg), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule